// File: doc/BRIEF.md
# Flash page-buffer erase-program controller

This block lets firmware rewrite a chosen set of bytes inside one flash page in a single operation. Firmware sees four byte-wide registers on a simple write/read bus. It fills a 64-entry staging buffer through a data register. Every entry carries its own update flag. Firmware then issues one command, and the block walks the buffer from the lowest index to the highest. For every flagged entry it performs a byte erase and then a byte program on a request/done handshake toward the flash array.

While the walk runs, a stall output holds the CPU. An interrupt request ends the walk early and is reported in status. A normal finish is reported by a separate done flag. The target page comes from the high address register together with the top two bits of the low address register. The low six bits of the low address register pick the staging-buffer slot, and they advance by one after every data write.

Register offsets are: 0 control/status, 1 address low, 2 address high, 3 data (reads as 0).

Top module: `pgbuf_rewrite`

## Requirements
- R1: After reset the status byte reads 0, both address registers read 0, and `stall_o` and `fl_req_o` are low.
- R2: A data-register write stores the byte in the buffer slot given by address-low bits [5:0] and sets that slot's update flag.
- R3: Each data-register write increments address-low bits [5:0] by one, wrapping from 63 to 0, while bits [7:6] stay unchanged.
- R4: A data write to a slot whose flag is already set leaves that slot's byte unchanged, and the address still increments.
- R5: Control command 0x00 (load) clears every buffer byte and every update flag, so a following cycle issues no flash request.
- R6: Control command 0x68 starts a cycle. Each flagged slot, in ascending index order, gets one erase and then one program. The flash byte address is {address-high, address-low[7:6], slot}, and the program data is the slot's byte. Unflagged slots get no request.
- R7: `fl_op_o` is 0 for erase and 1 for program. `fl_req_o` stays high with a stable address and op until `fl_done_i` pulses. Only one request is outstanding at a time, and an erase is always followed by a program of the same address.
- R8: From the clock edge that accepts the start command, `stall_o` and status bit 1 (busy) stay high until the cycle completes or aborts.
- R9: An `irq_i` during a cycle aborts it on the next edge. `stall_o` and `fl_req_o` drop, status bit 0 (interrupted) is set, and bit 2 stays clear.
- R10: A cycle that finishes normally sets status bit 2 (done) and leaves bit 0 clear.
- R11: Any write to the control register clears status bits 0 and 2. Codes other than 0x00 and 0x68 do nothing else: no cycle starts and the buffer and flags are kept.
- R12: `irq_i` while no cycle runs has no effect on status or stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_i | input | 1 | Interrupt request; aborts a running cycle |
| stall_o | output | 1 | CPU stall while a cycle runs |
| fl_req_o | output | 1 | Flash operation request, held until done |
| fl_op_o | output | 1 | 0 erase, 1 program |
| fl_addr_o | output | 16 | Flash byte address |
| fl_wdata_o | output | 8 | Program data |
| fl_done_i | input | 1 | One-cycle completion pulse from flash |

## Verification
The assertions check the following on every cycle:
- the request/done handshake stays stable, and a request never appears outside a stall;
- every finished erase is immediately followed by a program of the same address;
- an interrupt during a cycle drops the stall and sets the interrupted flag;
- the done and interrupted flags never coexist;
- address-low advances with its page bits fixed.

Only the bench scenarios can show the rest:
- the flash traffic matches the flagged slots exactly, in ascending order, with the right data;
- a repeated write leaves the first byte in place;
- the load command empties the flags;
- unknown command codes only clear status.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ALO  = 2'd1;
  localparam logic [1:0] REG_AHI  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam logic [7:0] CMD_LOAD = 8'h00;
  localparam logic [7:0] CMD_ERPG = 8'h68;

  localparam int STS_OI   = 0;
  localparam int STS_BUSY = 1;
  localparam int STS_DONE = 2;

  localparam logic OP_ERASE = 1'b0;
  localparam logic OP_PROG  = 1'b1;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SCAN  = 2'd1,
    S_ERASE = 2'd2,
    S_PROG  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_flag_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      flag_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i && !flag_q[wr_idx_i]) begin
      // first write after load wins; repeats are dropped
      mem_q[wr_idx_i]  <= wr_data_i;
      flag_q[wr_idx_i] <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_flag_o = flag_q[rd_idx_i];
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
  import pgbuf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             irq_i,
  input  logic             flag_i,
  input  logic             fl_done_i,
  output logic [IDX_W-1:0] cur_o,
  output logic             fl_req_o,
  output logic             fl_op_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             abort_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    fin_o   = 1'b0;
    abort_o = 1'b0;
    if (state_q != S_IDLE && irq_i) begin
      state_d = S_IDLE;
      abort_o = 1'b1;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_d = S_SCAN;
          cur_d   = '0;
        end
        S_SCAN: begin
          if (flag_i) state_d = S_ERASE;
          else if (cur_q == LAST) begin
            state_d = S_IDLE;
            fin_o   = 1'b1;
          end else cur_d = cur_q + 1'b1;
        end
        S_ERASE: if (fl_done_i) state_d = S_PROG;
        S_PROG: if (fl_done_i) begin
          if (cur_q == LAST) begin
            state_d = S_IDLE;
            fin_o   = 1'b1;
          end else begin
            state_d = S_SCAN;
            cur_d   = cur_q + 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  assign cur_o    = cur_q;
  assign busy_o   = (state_q != S_IDLE);
  assign fl_req_o = (state_q == S_ERASE) || (state_q == S_PROG);
  assign fl_op_o  = (state_q == S_PROG) ? OP_PROG : OP_ERASE;
endmodule

// File: rtl/pgbuf_rewrite.sv
module pgbuf_rewrite
  import pgbuf_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LO_W  = 8,
  parameter int HI_W  = 8,
  localparam int FA_W = HI_W + LO_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_wr_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  input  logic            irq_i,
  output logic            stall_o,
  output logic            fl_req_o,
  output logic            fl_op_o,
  output logic [FA_W-1:0] fl_addr_o,
  output logic [7:0]      fl_wdata_o,
  input  logic            fl_done_i
);
  logic [LO_W-1:0]  adr_lo_q;
  logic [HI_W-1:0]  adr_hi_q;
  logic             oi_q, done_q;
  logic             busy, fin, abort;
  logic [IDX_W-1:0] cur;
  logic             cur_flag;
  logic             wr_ok, ctrl_wr, data_wr, start, load;

  // bus writes are dropped while stalled
  assign wr_ok   = reg_wr_i && !busy;
  assign ctrl_wr = wr_ok && (reg_addr_i == REG_CTRL);
  assign data_wr = wr_ok && (reg_addr_i == REG_DATA);
  assign start   = ctrl_wr && (reg_wdata_i == CMD_ERPG);
  assign load    = ctrl_wr && (reg_wdata_i == CMD_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_lo_q <= '0;
      adr_hi_q <= '0;
    end else if (wr_ok && reg_addr_i == REG_ALO) begin
      adr_lo_q <= reg_wdata_i[LO_W-1:0];
    end else if (wr_ok && reg_addr_i == REG_AHI) begin
      adr_hi_q <= reg_wdata_i[HI_W-1:0];
    end else if (data_wr) begin
      adr_lo_q[IDX_W-1:0] <= adr_lo_q[IDX_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oi_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (ctrl_wr) begin
      oi_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (abort) oi_q   <= 1'b1;
      if (fin)   done_q <= 1'b1;
    end
  end

  pgbuf_store #(.IDX_W(IDX_W), .DATA_W(8)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (load),
    .wr_i      (data_wr),
    .wr_idx_i  (adr_lo_q[IDX_W-1:0]),
    .wr_data_i (reg_wdata_i),
    .rd_idx_i  (cur),
    .rd_data_o (fl_wdata_o),
    .rd_flag_o (cur_flag)
  );

  pgbuf_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .irq_i     (irq_i),
    .flag_i    (cur_flag),
    .fl_done_i (fl_done_i),
    .cur_o     (cur),
    .fl_req_o  (fl_req_o),
    .fl_op_o   (fl_op_o),
    .busy_o    (busy),
    .fin_o     (fin),
    .abort_o   (abort)
  );

  assign stall_o   = busy;
  assign fl_addr_o = {adr_hi_q, adr_lo_q[LO_W-1:IDX_W], cur};

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[STS_OI]   = oi_q;
        reg_rdata_o[STS_BUSY] = busy;
        reg_rdata_o[STS_DONE] = done_q;
      end
      REG_ALO: reg_rdata_o[LO_W-1:0] = adr_lo_q;
      REG_AHI: reg_rdata_o[HI_W-1:0] = adr_hi_q;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk
  import pgbuf_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LO_W  = 8,
  parameter int FA_W  = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_wr_i,
  input logic [1:0]      reg_addr_i,
  input logic [7:0]      reg_wdata_i,
  input logic            irq_i,
  input logic            stall_o,
  input logic            fl_req_o,
  input logic            fl_op_o,
  input logic [FA_W-1:0] fl_addr_o,
  input logic            fl_done_i,
  input logic [LO_W-1:0] adr_lo_q,
  input logic            oi_q,
  input logic            done_q
);
  p_req_in_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> stall_o);

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_done_i && !irq_i) |=>
      (fl_req_o && $stable(fl_addr_o) && $stable(fl_op_o)));

  p_erase_then_prog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_done_i && fl_op_o == OP_ERASE && !irq_i) |=>
      (fl_req_o && fl_op_o == OP_PROG && $stable(fl_addr_o)));

  p_start_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == REG_CTRL && reg_wdata_i == CMD_ERPG && !stall_o)
      |=> stall_o);

  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && irq_i) |=> (!stall_o && !fl_req_o && oi_q && !done_q));

  p_flags_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oi_q && done_q));

  p_idle_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && irq_i && !reg_wr_i) |=> ($stable(oi_q) && !stall_o));

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == REG_DATA && !stall_o) |=>
      (adr_lo_q[LO_W-1:IDX_W] == $past(adr_lo_q[LO_W-1:IDX_W]) &&
       adr_lo_q[IDX_W-1:0] == IDX_W'($past(adr_lo_q[IDX_W-1:0]) + 1'b1)));
endmodule

bind pgbuf_rewrite pgbuf_chk #(.IDX_W(IDX_W), .LO_W(LO_W), .FA_W(FA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_i       (irq_i),
  .stall_o     (stall_o),
  .fl_req_o    (fl_req_o),
  .fl_op_o     (fl_op_o),
  .fl_addr_o   (fl_addr_o),
  .fl_done_i   (fl_done_i),
  .adr_lo_q    (adr_lo_q),
  .oi_q        (oi_q),
  .done_q      (done_q)
);

// File: tb/pgbuf_rewrite_tb.sv
module pgbuf_rewrite_tb;
  localparam int FA_W = 16;
  localparam int LAT  = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            reg_wr_i = 1'b0;
  logic [1:0]      reg_addr_i = '0;
  logic [7:0]      reg_wdata_i = '0;
  logic [7:0]      reg_rdata_o;
  logic            irq_i = 1'b0;
  logic            stall_o, fl_req_o, fl_op_o;
  logic [FA_W-1:0] fl_addr_o;
  logic [7:0]      fl_wdata_o;
  logic            fl_done_i = 1'b0;

  always #5 clk = ~clk;

  pgbuf_rewrite u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_i(irq_i),
    .stall_o(stall_o), .fl_req_o(fl_req_o), .fl_op_o(fl_op_o),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_done_i(fl_done_i)
  );

  typedef struct packed {
    logic            op;
    logic [FA_W-1:0] addr;
    logic [7:0]      data;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // flash model and monitor: one request accepted, done after LAT cycles
  always @(negedge clk) begin
    if (fl_done_i) fl_done_i <= 1'b0;
    else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) fl_done_i <= 1'b1;
    end else if (fl_req_o) begin
      cnt <= LAT;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected op act=%0h/%0h exp=none", fl_op_o, fl_addr_o);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (fl_op_o !== e.op || fl_addr_o !== e.addr ||
            (e.op && fl_wdata_o !== e.data)) begin
          errors++;
          $display("FAIL R6 op act=%0h/%0h/%0h exp=%0h/%0h/%0h",
                   fl_op_o, fl_addr_o, fl_wdata_o, e.op, e.addr, e.data);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (stall_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic push_byte(input logic [7:0] hi, input logic [1:0] pg,
                           input logic [5:0] idx, input logic [7:0] d);
    exp_q.push_back('{op: 1'b0, addr: {hi, pg, idx}, data: 8'h00});
    exp_q.push_back('{op: 1'b1, addr: {hi, pg, idx}, data: d});
  endtask

  task automatic push_main();
    push_byte(8'h12, 2'b11, 6'd0,  8'hB2);
    push_byte(8'h12, 2'b11, 6'd3,  8'hA0);
    push_byte(8'h12, 2'b11, 6'd4,  8'hA1);
    push_byte(8'h12, 2'b11, 6'd62, 8'hB0);
    push_byte(8'h12, 2'b11, 6'd63, 8'hB1);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 status", v, 8'h00);
    rd(2'd1, v); chk("R1 addr low", v, 8'h00);
    rd(2'd2, v); chk("R1 addr high", v, 8'h00);
    chk("R1 stall/req", {stall_o, fl_req_o}, 2'b00);

    // R2/R3 fill, wrap, R4 repeat write
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h12);
    wr(2'd1, 8'hC3);
    wr(2'd3, 8'hA0);
    wr(2'd3, 8'hA1);
    rd(2'd1, v); chk("R3 increment", v, 8'hC5);
    wr(2'd1, 8'hFE);
    wr(2'd3, 8'hB0);
    wr(2'd3, 8'hB1);
    wr(2'd3, 8'hB2);
    rd(2'd1, v); chk("R3 wrap keeps page bits", v, 8'hC1);
    wr(2'd1, 8'hC3);
    wr(2'd3, 8'h55);
    rd(2'd1, v); chk("R4 address still increments", v, 8'hC4);

    // R6/R8/R10 full cycle, R2 data and R4 kept first byte checked by scoreboard
    push_main();
    wr(2'd0, 8'h68);
    chk("R8 stall after start", stall_o, 1'b1);
    rd(2'd0, v); chk("R8 busy bit", v, 8'h02);
    wait_idle();
    chk("R8 stall released", stall_o, 1'b0);
    rd(2'd0, v); chk("R10 done set", v, 8'h04);
    chk("R6 all ops seen", exp_q.size(), 0);

    // R11 unknown code clears status, starts nothing, keeps flags
    wr(2'd0, 8'h33);
    rd(2'd0, v); chk("R11 status cleared", v, 8'h00);
    repeat (5) @(negedge clk);
    chk("R11 no start", stall_o, 1'b0);
    push_main();
    wr(2'd0, 8'h68);
    wait_idle();
    rd(2'd0, v); chk("R11 buffer kept, R10 done", v, 8'h04);
    chk("R11 ops replayed", exp_q.size(), 0);

    // R5 load clears flags
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h68);
    wait_idle();
    rd(2'd0, v); chk("R5 empty cycle done", v, 8'h04);
    chk("R5 no flash ops", exp_q.size(), 0);

    // R9 abort
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h05);
    wr(2'd3, 8'h9A);
    exp_q.push_back('{op: 1'b0, addr: {8'h40, 2'b00, 6'd5}, data: 8'h00});
    wr(2'd0, 8'h68);
    begin
      int n = 0;
      while (!fl_req_o && n < 200) begin
        @(negedge clk);
        n++;
      end
    end
    chk("R7 erase requested", {fl_req_o, fl_op_o}, 2'b10);
    irq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0;
    chk("R9 stall/req dropped", {stall_o, fl_req_o}, 2'b00);
    rd(2'd0, v); chk("R9 interrupted flag", v, 8'h01);
    repeat (8) @(negedge clk);
    chk("R9 no further ops", exp_q.size(), 0);

    // R12 idle interrupt ignored
    wr(2'd0, 8'h33);
    irq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0;
    @(negedge clk);
    rd(2'd0, v); chk("R12 status untouched", v, 8'h00);
    chk("R12 no stall", stall_o, 1'b0);

    summary();
    $finish;
  end
endmodule